// File: doc/BRIEF.md
# Nibble-Configurable Handshake I/O Port

This block is an 8-bit general-purpose I/O port for a small microcontroller. A register bus reaches three registers: the port data register, a direction mode register and an auxiliary mode register. Each 4-bit half of the port is set as input or output by a two-bit field in the mode register. The pin side has an output-enable vector, an output vector and an input vector, all driven or sampled in step with the system clock.

A read of the port data register returns the levels on the pins, not the contents of the output register. An open-drain output therefore reads back whatever level the outside circuit forces. When bit 2 of the auxiliary register is set and both halves have the same direction, a two-wire strobe handshake governs the whole port, and the upper half's direction decides which way it runs. Handshake pin A is always an input to the block and pin B is always an output, but their meaning swaps with direction.

For input transfers, pin A is the data-valid strobe and pin B is the ready line. For output transfers, pin A is the external ready line and pin B is the data-valid strobe. Reads of an input port under handshake return the byte captured at the strobe, not the live pins.

Top module: `hsk_io_port`

## Requirements
- R1: After reset, `pin_oe` is 0x00 and `hsb_out` is 1. The mode register reads 0x41 (both halves input). The auxiliary register reads 0x00.
- R2: A write to address 0x00 with `bus_bank` = 0 stores the byte in the output register, which drives `pin_out`. The same write with `bus_bank` = 1 leaves `pin_out` unchanged.
- R3: Outside input handshake, a read of address 0x00 (bank 0) returns `pin_in` for both halves, whatever the output register holds.
- R4: Mode bits [1:0] set the lower half (bits 3:0). The value 2'b00 makes it an output (`pin_oe[3:0]` = 0xF). The value 2'b01 makes it an input. The reserved values 2'b10 and 2'b11 also make it an input.
- R5: Mode bits [7:6] set the upper half (bits 7:4), with the same encoding as R4.
- R6: The handshake runs only when auxiliary bit 2 is 1 and both halves have the same direction. Otherwise `hsb_out` stays 1 and reads return live pins.
- R7: In input handshake (both halves input), a falling edge on `hsa_in` while the port is empty captures `pin_in`. One clock later, `hsb_out` (ready) is 0.
- R8: While the captured byte is held, reads of the data register return the captured byte, even after `pin_in` changes.
- R9: Ready (`hsb_out`) returns to 1 only once the data register has been read and `hsa_in` is high. It rises in the cycle after both conditions hold.
- R10: In output handshake (both halves output), a data write drives `hsb_out` (data valid) to 0 one clock after the write if `hsa_in` is 1 at the write. Otherwise it goes low one clock after `hsa_in` is first seen high.
- R11: Data valid returns to 1 one clock after `hsa_in` is sampled low. It is not driven low again until a new data write.
- R12: A data write made while data valid is low is remembered. After the current transfer ends, data valid is issued again once `hsa_in` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (consumes handshake input data) |
| bus_addr | input | 8 | Register address: 0x00 data, 0xF8 mode, 0xF7 auxiliary mode |
| bus_bank | input | 1 | Register bank; the data register is selected only in bank 0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_oe | output | 8 | Per-bit output enable, one value per half |
| pin_out | output | 8 | Output register value |
| pin_in | input | 8 | Levels sampled on the pins |
| hsa_in | input | 1 | Handshake pin A: data-valid strobe in (input mode) or ready in (output mode) |
| hsb_out | output | 1 | Handshake pin B: ready out (input mode) or data valid out (output mode) |

## Verification
The bench tries every direction code, including the reserved ones. A design that decoded 2'b10 or 2'b11 as an output would drive pins it should leave free. It sets up mixed-direction ports with the enable bit set and writes with the bank bit raised. A design that ignored the direction match or the bank would strobe ready or overwrite the output register.

In input handshake, the bench changes the pins after capture and holds the strobe high before the read. A design that read live pins, or released ready without a read, shows a wrong byte or an early ready. In output handshake, it writes while ready is low and writes again during a transfer. A design that strobed without ready, re-strobed on its own or dropped the second write breaks the expected data-valid sequence.

// File: rtl/hsk_io_pkg.sv
// Package: shared encodings for the handshake I/O port.
// Assumes nibble direction fields are two bits wide.
package hsk_io_pkg;

    // Direction field codes; only NIB_OUT makes a half drive its pins.
    typedef enum logic [1:0] {
        NIB_OUT  = 2'b00,
        NIB_IN   = 2'b01,
        NIB_RSV2 = 2'b10,
        NIB_RSV3 = 2'b11
    } nib_mode_e;

    // Input handshake holding state.
    typedef enum logic {
        IN_EMPTY = 1'b0,
        IN_FULL  = 1'b1
    } in_state_e;

    // Output handshake sequencing state.
    typedef enum logic [1:0] {
        OUT_IDLE  = 2'b00,
        OUT_PEND  = 2'b01,
        OUT_VALID = 2'b10
    } out_state_e;

    // True when a direction field selects output; reserved codes read as input.
    function automatic logic nib_is_out(input logic [1:0] field);
        return nib_mode_e'(field) == NIB_OUT;
    endfunction

endpackage

// File: rtl/hsk_io_regs.sv
// Module: register file of the port. It holds the output register, the
// direction mode register and the auxiliary mode register, and decodes
// bus selects. Assumes single-cycle bus strobes sampled on the rising clock.
module hsk_io_regs #(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  DATA_ADDR = 8'h00,
    parameter logic [7:0]  MODE_ADDR = 8'hF8,
    parameter logic [7:0]  AUX_ADDR  = 8'hF7,
    parameter logic [7:0]  MODE_RST  = 8'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_bank,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] aux_q,
    output logic [DATA_W-1:0] out_q,
    output logic              data_sel,
    output logic              mode_sel,
    output logic              aux_sel,
    output logic              data_wr,
    output logic              data_rd
);

    // Address decode; the data register needs bank 0.
    always_comb begin
        data_sel = (bus_addr == ADDR_W'(DATA_ADDR)) && !bus_bank;
        mode_sel = (bus_addr == ADDR_W'(MODE_ADDR));
        aux_sel  = (bus_addr == ADDR_W'(AUX_ADDR));
        data_wr  = bus_wr && data_sel;
        data_rd  = bus_rd && data_sel;
    end

    // Register updates from bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= DATA_W'(MODE_RST);
            aux_q  <= '0;
            out_q  <= '0;
        end else if (bus_wr) begin
            if (data_sel) out_q  <= bus_wdata;
            if (mode_sel) mode_q <= bus_wdata;
            if (aux_sel)  aux_q  <= bus_wdata;
        end
    end

    // R2: a write aimed at bank 1 never alters the output register.
    assert_bank_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_bank && !mode_sel && !aux_sel) |=> $stable(out_q));

endmodule

// File: rtl/hsk_io_in_hsk.sv
// Module: input-direction handshake. Pin A is the data-valid strobe and the
// ready output goes to pin B. Assumes strobe and pin inputs are already
// synchronous to clk. Outside active mode it idles empty with ready high.
module hsk_io_in_hsk
    import hsk_io_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              dav_in,
    input  logic              rd_pulse,
    input  logic [DATA_W-1:0] pin_in,
    output logic              rdy_out,
    output logic [DATA_W-1:0] cap_q
);

    in_state_e state_q;
    logic      dav_q;
    logic      rd_seen_q;
    logic      fall;

    // Falling strobe detection against the previous sample.
    always_comb fall = dav_q && !dav_in;

    // Previous strobe level, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) dav_q <= 1'b1;
        else        dav_q <= dav_in;
    end

    // Capture, hold and release sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state_q   <= IN_EMPTY;
            rd_seen_q <= 1'b0;
            if (!rst_n) cap_q <= '0;
        end else begin
            unique case (state_q)
                IN_EMPTY: if (fall) begin
                    cap_q     <= pin_in;
                    state_q   <= IN_FULL;
                    rd_seen_q <= 1'b0;
                end
                IN_FULL: begin
                    if ((rd_seen_q || rd_pulse) && dav_in) begin
                        state_q   <= IN_EMPTY;
                        rd_seen_q <= 1'b0;
                    end else if (rd_pulse) begin
                        rd_seen_q <= 1'b1;
                    end
                end
                default: state_q <= IN_EMPTY;
            endcase
        end
    end

    // Ready is high while nothing is held.
    always_comb rdy_out = (state_q == IN_EMPTY);

    // R7: a strobe fall on an empty port captures the pins and drops ready.
    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rdy_out && dav_q && !dav_in) |=> (!rdy_out && cap_q == $past(pin_in)));

    // R8: the held byte does not move while full.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !rdy_out) |=> $stable(cap_q));

    // R9: ready cannot return while the strobe is still low.
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !rdy_out && !dav_in) |=> (!rdy_out || !active));

endmodule

// File: rtl/hsk_io_out_hsk.sv
// Module: output-direction handshake. Pin A is the external ready and pin B
// carries data valid (low = valid). Assumes ready is synchronous to clk.
// Outside active mode it idles with data valid high.
module hsk_io_out_hsk
    import hsk_io_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rdy_in,
    input  logic wr_pulse,
    output logic dav_out
);

    out_state_e state_q;
    logic       again_q;

    // Transfer sequencing: write -> wait ready -> valid -> wait ready low.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state_q <= OUT_IDLE;
            again_q <= 1'b0;
        end else begin
            unique case (state_q)
                OUT_IDLE, OUT_PEND: begin
                    if (rdy_in && (wr_pulse || state_q == OUT_PEND)) state_q <= OUT_VALID;
                    else if (wr_pulse)                                state_q <= OUT_PEND;
                end
                OUT_VALID: begin
                    if (!rdy_in) begin
                        state_q <= (again_q || wr_pulse) ? OUT_PEND : OUT_IDLE;
                        again_q <= 1'b0;
                    end else if (wr_pulse) begin
                        again_q <= 1'b1;
                    end
                end
                default: state_q <= OUT_IDLE;
            endcase
        end
    end

    // Data valid is active low.
    always_comb dav_out = (state_q != OUT_VALID);

    // R10: data valid only falls after ready was seen high.
    assert_dav_needs_rdy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dav_out) |-> $past(rdy_in));

    // R11: data valid stays low while ready stays high.
    assert_dav_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!dav_out && rdy_in) |=> (!dav_out || !active));

endmodule

// File: rtl/hsk_io_port.sv
// Module: top of the nibble-configurable handshake I/O port. It derives per-half
// direction, enables handshake when both halves agree, muxes read data and
// merges the two handshake engines onto pin B. Assumes all pin inputs are
// synchronous to clk; level shifting is outside this block.
module hsk_io_port
    import hsk_io_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  DATA_ADDR = 8'h00,
    parameter logic [7:0]  MODE_ADDR = 8'hF8,
    parameter logic [7:0]  AUX_ADDR  = 8'hF7,
    parameter int          HS_BIT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_bank,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] pin_out,
    input  logic [DATA_W-1:0] pin_in,
    input  logic              hsa_in,
    output logic              hsb_out
);

    localparam int NIB_W  = DATA_W / 2;
    localparam logic [7:0] MODE_RST = 8'h41;

    logic [DATA_W-1:0] mode_q, aux_q, out_q, cap_q, port_rd;
    logic              data_sel, mode_sel, aux_sel, data_wr, data_rd;
    logic [1:0]        nib_out;
    logic              hs_on, hs_in_act, hs_out_act, rdy_out, dav_out;

    hsk_io_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR),
        .MODE_ADDR(MODE_ADDR), .AUX_ADDR(AUX_ADDR), .MODE_RST(MODE_RST)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_bank(bus_bank), .bus_wdata(bus_wdata),
        .mode_q(mode_q), .aux_q(aux_q), .out_q(out_q),
        .data_sel(data_sel), .mode_sel(mode_sel), .aux_sel(aux_sel),
        .data_wr(data_wr), .data_rd(data_rd)
    );

    // Per-half direction, output enable and read-back source.
    for (genvar g = 0; g < 2; g++) begin : g_nib
        localparam int FLD_LO = (g == 0) ? 0 : DATA_W - 2;
        // Decode this half's direction field.
        always_comb nib_out[g] = nib_is_out(mode_q[FLD_LO +: 2]);
        // Drive enables and choose captured or live data for reads.
        always_comb begin
            pin_oe[g*NIB_W +: NIB_W]  = {NIB_W{nib_out[g]}};
            port_rd[g*NIB_W +: NIB_W] = hs_in_act ? cap_q[g*NIB_W +: NIB_W]
                                                  : pin_in[g*NIB_W +: NIB_W];
        end
    end

    // Handshake enable needs the control bit and matching halves.
    always_comb begin
        hs_on      = aux_q[HS_BIT] && (nib_out[0] == nib_out[1]);
        hs_in_act  = hs_on && !nib_out[1];
        hs_out_act = hs_on &&  nib_out[1];
    end

    hsk_io_in_hsk #(.DATA_W(DATA_W)) in_hsk_i (
        .clk(clk), .rst_n(rst_n), .active(hs_in_act), .dav_in(hsa_in),
        .rd_pulse(data_rd), .pin_in(pin_in), .rdy_out(rdy_out), .cap_q(cap_q)
    );

    hsk_io_out_hsk out_hsk_i (
        .clk(clk), .rst_n(rst_n), .active(hs_out_act), .rdy_in(hsa_in),
        .wr_pulse(data_wr), .dav_out(dav_out)
    );

    // Pin B: each engine idles high, so combine with AND.
    always_comb hsb_out = rdy_out && dav_out;

    // Output register straight to the pins.
    always_comb pin_out = out_q;

    // Register read multiplexer.
    always_comb begin
        if (data_sel)      bus_rdata = port_rd;
        else if (mode_sel) bus_rdata = mode_q;
        else if (aux_sel)  bus_rdata = aux_q;
        else               bus_rdata = '0;
    end

    // R4: the lower half's enables always agree with each other.
    assert_oe_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[NIB_W-1:0] == '0) || (pin_oe[NIB_W-1:0] == '1));

    // R5: the upper half's enables always agree with each other.
    assert_oe_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe[DATA_W-1:NIB_W] == '0) || (pin_oe[DATA_W-1:NIB_W] == '1));

    // R6: pin B stays idle while handshake is not in force.
    assert_hsb_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_on && $past(!hs_on)) |-> hsb_out);

endmodule

// File: tb/hsk_io_port_tb.sv
module hsk_io_port_tb_top;

    localparam logic [7:0] A_DATA = 8'h00;
    localparam logic [7:0] A_MODE = 8'hF8;
    localparam logic [7:0] A_AUX  = 8'hF7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_bank = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, pin_in = '0;
    logic [7:0] bus_rdata, pin_oe, pin_out;
    logic       hsa_in = 1'b1;
    logic       hsb_out;
    int         total = 0, bad = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    hsk_io_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_bank(bus_bank), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_oe(pin_oe), .pin_out(pin_out),
        .pin_in(pin_in), .hsa_in(hsa_in), .hsb_out(hsb_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic bank, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_bank = bank; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_bank = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_bank = 1'b0;
        #1 chk(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 hsb", {7'd0, hsb_out}, 8'h01);
        rd(A_MODE, 8'h41, "R1 mode");
        rd(A_AUX, 8'h00, "R1 aux");
    endtask

    task automatic t_data;
        wr(A_MODE, 1'b0, 8'h00);
        chk("R4 R5 all out", pin_oe, 8'hFF);
        wr(A_DATA, 1'b0, 8'hA5);
        chk("R2 store", pin_out, 8'hA5);
        wr(A_DATA, 1'b1, 8'h3C);
        chk("R2 bank1 ignored", pin_out, 8'hA5);
        pin_in = 8'h5A;
        rd(A_DATA, 8'h5A, "R3 reads pins");
    endtask

    task automatic t_modes;
        wr(A_MODE, 1'b0, 8'h01); chk("R4 lo in", pin_oe, 8'hF0);
        wr(A_MODE, 1'b0, 8'h02); chk("R4 lo rsv2", pin_oe, 8'hF0);
        wr(A_MODE, 1'b0, 8'h03); chk("R4 lo rsv3", pin_oe, 8'hF0);
        wr(A_MODE, 1'b0, 8'h40); chk("R5 hi in", pin_oe, 8'h0F);
        wr(A_MODE, 1'b0, 8'h80); chk("R5 hi rsv2", pin_oe, 8'h0F);
        wr(A_MODE, 1'b0, 8'hC0); chk("R5 hi rsv3", pin_oe, 8'h0F);
    endtask

    task automatic t_no_hs;
        wr(A_MODE, 1'b0, 8'h40);
        wr(A_AUX, 1'b0, 8'h04);
        hsa_in = 1'b1; pin_in = 8'h11; tick(2);
        hsa_in = 1'b0; tick(2);
        chk("R6 mismatch hsb", {7'd0, hsb_out}, 8'h01);
        pin_in = 8'h22;
        rd(A_DATA, 8'h22, "R6 mismatch live");
        hsa_in = 1'b1;
        wr(A_MODE, 1'b0, 8'h41);
        wr(A_AUX, 1'b0, 8'h00);
        tick(1); hsa_in = 1'b0; tick(2);
        chk("R6 disabled hsb", {7'd0, hsb_out}, 8'h01);
        pin_in = 8'h33;
        rd(A_DATA, 8'h33, "R6 disabled live");
        hsa_in = 1'b1; tick(1);
    endtask

    task automatic t_in_hs;
        wr(A_MODE, 1'b0, 8'h41);
        wr(A_AUX, 1'b0, 8'h04);
        hsa_in = 1'b1; tick(2);
        chk("R9 idle ready", {7'd0, hsb_out}, 8'h01);
        pin_in = 8'h96; hsa_in = 1'b0; tick(1);
        chk("R7 ready low", {7'd0, hsb_out}, 8'h00);
        hsa_in = 1'b1; pin_in = 8'h00; tick(2);
        chk("R9 no read keeps low", {7'd0, hsb_out}, 8'h00);
        rd(A_DATA, 8'h96, "R8 captured");
        chk("R9 ready after read", {7'd0, hsb_out}, 8'h01);
        pin_in = 8'h3B; hsa_in = 1'b0; tick(1);
        chk("R7 second capture", {7'd0, hsb_out}, 8'h00);
        pin_in = 8'hFF;
        rd(A_DATA, 8'h3B, "R8 second captured");
        chk("R9 strobe low keeps", {7'd0, hsb_out}, 8'h00);
        hsa_in = 1'b1; tick(1);
        chk("R9 release", {7'd0, hsb_out}, 8'h01);
    endtask

    task automatic t_out_hs;
        wr(A_MODE, 1'b0, 8'h00);
        wr(A_AUX, 1'b0, 8'h04);
        hsa_in = 1'b0; tick(1);
        wr(A_DATA, 1'b0, 8'h77);
        chk("R2 out data", pin_out, 8'h77);
        chk("R10 wait ready", {7'd0, hsb_out}, 8'h01);
        tick(2);
        chk("R10 still waiting", {7'd0, hsb_out}, 8'h01);
        hsa_in = 1'b1; tick(1);
        chk("R10 valid on ready", {7'd0, hsb_out}, 8'h00);
        tick(2);
        chk("R11 valid held", {7'd0, hsb_out}, 8'h00);
        hsa_in = 1'b0; tick(1);
        chk("R11 valid ends", {7'd0, hsb_out}, 8'h01);
        hsa_in = 1'b1; tick(3);
        chk("R11 no new valid", {7'd0, hsb_out}, 8'h01);
        wr(A_DATA, 1'b0, 8'h12);
        chk("R10 immediate valid", {7'd0, hsb_out}, 8'h00);
        wr(A_DATA, 1'b0, 8'h34);
        chk("R12 still valid", {7'd0, hsb_out}, 8'h00);
        hsa_in = 1'b0; tick(1);
        chk("R12 gap", {7'd0, hsb_out}, 8'h01);
        hsa_in = 1'b1; tick(1);
        chk("R12 reissued", {7'd0, hsb_out}, 8'h00);
        chk("R12 data", pin_out, 8'h34);
        hsa_in = 1'b0; tick(1);
        chk("R11 final idle", {7'd0, hsb_out}, 8'h01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        t_reset;
        t_data;
        t_modes;
        t_no_hs;
        t_in_hs;
        t_out_hs;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule